// File: doc/BRIEF.md
# HDLC Bit-Stuffing Transmit Framer

This block turns a frame presented as a stream of bytes into the octet stream that goes out on a 64 kbit/s or 56 kbit/s synchronous channel carrying HDLC. Each frame is wrapped in two 0x7E flags, which are never stuffed. In between come the payload bits and a 16-bit frame check sequence. A 0 bit is inserted after every run of five 1 bits.

Bits go onto the line least significant bit first and are packed into line octets from bit 0 upward. In 56k mode only seven line bits fit into each octet, and the top bit of every octet is held at 1. When a frame ends part way through an octet, the rest of that octet is filled with 1s and one extra 0xFF octet follows. When no frame is pending, the line carries 0xFF idle octets.

Both sides use a valid/ready handshake. The output register holds its octet while the consumer stalls, and the bit engine waits with it.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Every frame begins and ends with the flag pattern 0x7E, sent without zero insertion. In 64k mode the first octet of a frame is 0x7E; in 56k mode it is 0xFE.
- R2: Line bits are sent least significant bit first. The first line bit of an octet sits in bit 0 of `out_data`, and later bits sit in rising positions.
- R3: After five consecutive 1 bits of payload or check sequence, a 0 bit is inserted and the run count restarts.
- R4: The check sequence is the bit-reflected CRC-16 with polynomial 0x8408 and start value 0xFFFF. It is computed over the payload only, inverted, and sent low byte first.
- R5: With `mode`=1 (56k), each line octet holds 7 line bits in bits 0..6 and has bit 7 set to 1. With `mode`=0 (64k), each line octet holds 8 line bits.
- R6: If the closing flag ends inside an octet, the unused positions of that octet are 1s, and exactly one 0xFF octet follows before the next frame can start. If it ends on an octet boundary, no extra octet is added.
- R7: With no frame in progress, every line octet is 0xFF. A new frame starts on an octet boundary as soon as its first byte is offered.
- R8: `mode` is sampled when the first byte of a frame is accepted. Changes to `mode` during the frame have no effect on that frame's octets.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged in the next cycle and `in_ready` is 0.
- R10: A pause in `in_valid` between bytes of a frame delays the frame but leaves its line octet sequence unchanged.
- R11: After reset `out_valid` is 0, `in_ready` is 1, and the first octet produced is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = 64k (8 bits per octet), 1 = 56k (7 bits per octet) |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Framer takes the offered byte this cycle |
| out_valid | output | 1 | Line octet available |
| out_data | output | 8 | Line octet |
| out_ready | input | 1 | Consumer takes the line octet this cycle |

## Verification
The hardest situation to observe is the single 0xFF octet that follows a frame whose closing flag ends inside an octet. At the ports it looks just like idle, and it shows only as a one-octet gap before the next frame. To make that gap visible, the stimulus offers each frame's first byte while the previous frame is still sending its check sequence, so frames run back to back. The number of 0xFF octets between them is then fixed by the partial/aligned outcome the reference model predicts. The same continuous stream also switches mode, pauses the input, flips `mode` mid-frame and throttles `out_ready`, so that stuffing state must survive every kind of stall.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter int          RUN      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam int        OW   = $clog2(RUN + 1);
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {S_IDLE, S_OFLAG, S_DATA, S_FCS, S_CFLAG, S_PAD, S_XTRA} st_t;

  st_t          st;
  logic [3:0]   idx;
  logic [7:0]   cur;
  logic         cur_last;
  logic [15:0]  crc;
  logic [OW-1:0] ones;
  logic         stf;
  logic         m56;
  logic [6:0]   sh;
  logic [2:0]   bc;
  logic [7:0]   obuf;
  logic         ovld;
  logic         lbit;

  wire frm_idle  = (st == S_IDLE);
  wire room      = !ovld || out_ready;
  wire need_byte = (st == S_DATA) && !stf && (idx == 4'd7) && !cur_last;
  wire start     = frm_idle && (bc == 3'd0) && in_valid && room;
  wire step      = room && !start && !(need_byte && !in_valid);

  assign in_ready  = room && ((frm_idle && bc == 3'd0) || need_byte);
  assign out_valid = ovld;
  assign out_data  = obuf;

  always_comb begin
    if (stf) lbit = 1'b0;
    else
      case (st)
        S_OFLAG, S_CFLAG: lbit = FLAG[idx[2:0]];
        S_DATA:           lbit = cur[idx[2:0]];
        S_FCS:            lbit = ~crc[0];
        default:          lbit = 1'b1;
      endcase
  end

  wire [15:0]   crc_sh   = {1'b0, crc[15:1]};
  wire [15:0]   crc_upd  = (crc[0] ^ lbit) ? (crc_sh ^ CRC_POLY) : crc_sh;
  wire          run_hit  = lbit && (ones == OW'(RUN - 1));
  wire [OW-1:0] ones_nx  = lbit ? ones + 1'b1 : '0;
  wire [7:0]    oct8     = {lbit, sh};
  wire          last_bit = m56 ? (bc == 3'd6) : (bc == 3'd7);
  wire [7:0]    line_oct = m56 ? {1'b1, oct8[7:1]} : oct8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  idx <= '0;  cur <= '0;  cur_last <= 1'b0;
      crc <= CRC_INIT;  ones <= '0;  stf <= 1'b0;  m56 <= 1'b0;
      sh <= '1;  bc <= '0;  obuf <= 8'hFF;  ovld <= 1'b0;
    end else begin
      if (ovld && out_ready) ovld <= 1'b0;
      if (start) begin
        cur <= in_data;  cur_last <= in_last;  m56 <= mode;
        st <= S_OFLAG;  idx <= '0;  crc <= CRC_INIT;  ones <= '0;  stf <= 1'b0;
      end else if (step) begin
        sh <= oct8[7:1];
        bc <= last_bit ? 3'd0 : bc + 3'd1;
        if (last_bit) begin
          obuf <= line_oct;
          ovld <= 1'b1;
        end
        if (stf) begin
          stf  <= 1'b0;
          ones <= '0;
        end else
          case (st)
            S_OFLAG: begin
              idx <= idx + 4'd1;
              if (idx == 4'd7) begin idx <= '0; st <= S_DATA; end
            end
            S_DATA: begin
              crc  <= crc_upd;
              ones <= run_hit ? '0 : ones_nx;
              stf  <= run_hit;
              idx  <= idx + 4'd1;
              if (idx == 4'd7) begin
                idx <= '0;
                if (cur_last) st <= S_FCS;
                else begin cur <= in_data; cur_last <= in_last; end
              end
            end
            S_FCS: begin
              crc  <= crc_sh;
              ones <= run_hit ? '0 : ones_nx;
              stf  <= run_hit;
              idx  <= idx + 4'd1;
              if (idx == 4'd15) begin idx <= '0; st <= S_CFLAG; end
            end
            S_CFLAG: begin
              idx <= idx + 4'd1;
              if (idx == 4'd7) begin
                idx <= '0;
                st  <= last_bit ? S_IDLE : S_PAD;
              end
            end
            S_PAD:   if (last_bit) st <= S_XTRA;
            S_XTRA:  if (last_bit) st <= S_IDLE;
            default: ;
          endcase
      end
    end
  end
endmodule

module hdlc_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       m56,
  input logic       idle
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (idle && in_valid && in_ready) pend <= 1'b1;
    else if (out_valid && out_ready) pend <= 1'b0;
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_TOP_ONE_56K: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && m56 |-> out_data[7]); // R5
  AST_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pend && out_valid |-> out_data == (m56 ? 8'hFE : 8'h7E)); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(m56)); // R8
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .m56(m56), .idle(frm_idle)
);

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  wire in_ready, out_valid;
  wire [7:0] out_data;

  always #10 clk = ~clk;

  hdlc_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  // {len[7:0], seed[7:0], kind[1:0], flip, gap, bp, mode}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {8'd1,  8'h00, 2'd3, 4'b0000},
    {8'd4,  8'h5A, 2'd0, 4'b0000},
    {8'd3,  8'h00, 2'd1, 4'b0000},
    {8'd2,  8'h00, 2'd2, 4'b0000},
    {8'd1,  8'h00, 2'd3, 4'b0001},
    {8'd5,  8'h33, 2'd0, 4'b0001},
    {8'd4,  8'h00, 2'd1, 4'b0001},
    {8'd16, 8'hC3, 2'd0, 4'b0010},
    {8'd9,  8'h11, 2'd0, 4'b0111},
    {8'd6,  8'h00, 2'd3, 4'b0100},
    {8'd5,  8'h77, 2'd0, 4'b1000},
    {8'd6,  8'h9D, 2'd0, 4'b1001}
  };

  int total = 0, bad = 0, cyc = 0;
  bit hold = 1'b0, bp_on = 1'b0;
  byte unsigned got[$], expq[$];
  int fbeg[$], flen[$];
  bit fpart[$];

  always @(negedge clk) begin
    cyc++;
    out_ready = hold ? 1'b0 : (bp_on ? ((cyc % 16) < 5) : 1'b1);
    #2;
    if (rst_n && out_valid && out_ready) got.push_back(out_data);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_bit(ref bit b[$], ref int ones, input bit x, input bit stuff);
    b.push_back(x);
    if (stuff) begin
      if (x) ones++; else ones = 0;
      if (ones == 5) begin b.push_back(1'b0); ones = 0; end
    end
  endtask

  task automatic model(input bit m56, input byte unsigned pl[$], ref byte unsigned o[$], output bit part);
    bit b[$];
    logic [15:0] c = 16'hFFFF;
    int ones = 0;
    int per = m56 ? 7 : 8;
    for (int k = 0; k < 8; k++) push_bit(b, ones, (8'h7E >> k) & 1, 1'b0);
    foreach (pl[i])
      for (int k = 0; k < 8; k++) begin
        bit x = pl[i][k];
        c = (c[0] ^ x) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        push_bit(b, ones, x, 1'b1);
      end
    c = ~c;
    for (int k = 0; k < 16; k++) push_bit(b, ones, c[k], 1'b1);
    for (int k = 0; k < 8; k++) push_bit(b, ones, (8'h7E >> k) & 1, 1'b0);
    for (int p = 0; p < b.size(); p += per) begin
      byte unsigned v = 8'hFF;
      for (int j = 0; j < per; j++) if (p + j < b.size()) v[j] = b[p + j];
      o.push_back(v);
    end
    part = (b.size() % per) != 0;
  endtask

  task automatic send_frame(input bit m56, input byte unsigned pl[$], input bit gap, input bit flip);
    foreach (pl[i]) begin
      @(negedge clk);
      if (i == 0) mode = m56;
      else if (i == 1 && flip) mode = ~m56;
      in_valid = 1'b1; in_data = pl[i]; in_last = (i == pl.size() - 1);
      #2;
      while (!in_ready) begin @(negedge clk); #2; end
      if (gap && i + 1 < pl.size()) begin
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic plan(input bit m56, input byte unsigned pl[$]);
    byte unsigned o[$];
    bit part;
    model(m56, pl, o, part);
    fbeg.push_back(expq.size()); flen.push_back(o.size()); fpart.push_back(part);
    foreach (o[i]) expq.push_back(o[i]);
    if (part) expq.push_back(8'hFF);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    byte unsigned pl[$];
    byte unsigned d0;
    int i0, nidle;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(out_valid === 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready === 1'b1, "R11 in_ready after reset", in_ready, 1);
    repeat (40) @(negedge clk);
    #3;
    ok = got.size() >= 4;
    foreach (got[i]) if (got[i] != 8'hFF) ok = 1'b0;
    chk(ok, "R7 R11 idle octets are 0xFF", got.size() > 0 ? got[0] : 0, 8'hFF);

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e = VEC[v];
      pl.delete();
      for (int i = 0; i < e[21:14]; i++)
        case (e[5:4])
          2'd0: pl.push_back(8'(e[13:6] + i * 73) ^ 8'(i << 3));
          2'd1: pl.push_back(8'hFF);
          2'd2: pl.push_back(8'h7E);
          default: pl.push_back(8'(i));
        endcase
      plan(e[0], pl);
      bp_on = e[1];
      send_frame(e[0], pl, e[2], e[3]);
    end
    bp_on = 1'b0;

    pl = '{8'hA5, 8'hFF, 8'h3C, 8'hF8};
    plan(1'b0, pl);
    fork
      send_frame(1'b0, pl, 1'b0, 1'b0);
      begin
        repeat (30) @(negedge clk);
        hold = 1'b1;
        @(negedge clk); #2;
        while (!out_valid) begin @(negedge clk); #2; end
        d0 = out_data;
        repeat (20) @(negedge clk);
        #2;
        chk(out_valid === 1'b1 && out_data === d0, "R9 octet held under stall", out_data, d0);
        chk(in_ready === 1'b0, "R9 no byte taken under stall", in_ready, 0);
        hold = 1'b0;
      end
    join
    repeat (300) @(negedge clk);
    #3;

    i0 = 0;
    while (i0 < got.size() && got[i0] == 8'hFF) i0++;
    chk(got.size() >= i0 + expq.size(), "R7 octet count", got.size() - i0, expq.size());
    if (got.size() >= i0 + expq.size()) begin
      for (int f = 0; f < fbeg.size(); f++) begin
        int bad_at = -1;
        for (int k = 0; k < flen[f]; k++)
          if (bad_at < 0 && got[i0 + fbeg[f] + k] != expq[fbeg[f] + k]) bad_at = k;
        if (bad_at < 0)
          chk(1'b1, "", 0, 0);
        else begin
          $display("  frame %0d octet %0d mismatch", f, bad_at);
          chk(1'b0, "R1 R2 R3 R4 R5 R8 R10 frame octets",
              got[i0 + fbeg[f] + bad_at], expq[fbeg[f] + bad_at]);
        end
        if (fpart[f]) begin
          int p = i0 + fbeg[f] + flen[f];
          chk(got[p] == 8'hFF, "R6 extra 0xFF after partial tail", got[p], 8'hFF);
        end
      end
      nidle = 0;
      for (int k = i0 + expq.size(); k < got.size(); k++) if (got[k] != 8'hFF) nidle++;
      chk(nidle == 0, "R7 idle after last frame", nidle, 0);
    end
    summary();
  end
endmodule